// File: doc/BRIEF.md
# Host Controller Interrupt Aggregator

This block gathers the six interrupt causes of a USB host controller into one interrupt request line. Hardware raises a cause by pulsing its bit on the event input for one cycle. That pulse sets a sticky status bit. Software sees these bits through a small register port with two registers: an enable register and a status register. Software acknowledges a cause by writing a 1 to its status bit. A cause can reach the interrupt line only while its enable bit and its status bit are both 1.

The causes fall into two classes. Host system error, frame list rollover and port change are urgent, so they drive the line at once. Transfer completion, transfer error and async-advance are batched. Each of these waits for the next interrupt-threshold boundary. A boundary comes from a counter of 125 us microframe tick pulses, and the threshold is selectable as a power of two from 1 to 64 microframes. Once released at a boundary, a batched cause holds the line until software clears it.

Top module: `hc_irq_aggr`

## Requirements
- R1: After reset, the enable register reads 0, the status register reads 0 and `irq_o` is 0.
- R2: The register port selects the enable register with `reg_sel_i`=0 and the status register with `reg_sel_i`=1. Enable bits 5:0 are read/write. Bits 31:6 of both registers always read 0, and writes to those bits have no effect.
- R3: Status bit positions are 0 transfer done, 1 transfer error, 2 port change, 3 frame list rollover, 4 host system error, 5 async advance. A 1 on `evt_i[n]` sets status bit n. A write to the status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event and a software clear hit the same status bit in the same cycle, the bit stays set.
- R5: A status bit never clears except through a software write.
- R6: An enabled status bit at positions 2, 3 or 4 sets `irq_o` on the clock edge after the status bit becomes 1, with no wait for a boundary.
- R7: An enabled status bit at positions 0, 1 or 5 raises `irq_o` only at a boundary that occurs while the status bit is already set. A boundary is the tick that completes 2^`thr_sel_i` ticks since reset or since the last boundary. Values 6 and 7 of `thr_sel_i` both mean 64 ticks. An event that arrives in the same cycle as a boundary tick waits for the following boundary.
- R8: A status bit whose enable bit is 0 never causes `irq_o`.
- R9: `irq_o` is registered and active high. It falls one cycle after the last qualifying status bit is cleared or its enable bit is cleared. Clearing an enable bit leaves the status bit unchanged.
- R10: After release, a batched cause keeps `irq_o` high across later ticks until its status bit is cleared. If the same cause is set again later, it waits for a new boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per 125 us microframe |
| thr_sel_i | input | 3 | Threshold select, 2^value microframes (6 and 7 mean 64) |
| evt_i | input | 6 | One-cycle event pulses, one per status bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Registered, level-sensitive interrupt request |

## Verification
The assertions run on every cycle and check that an event always leaves its status bit set, even when a clear hits the same bit. They check that a status bit falls only after a matching clear, that an enabled urgent cause raises the line on the next edge, and that the line never rises with no enabled cause behind it. They also check that a batched cause first rises only on a boundary strobe, and they check how the threshold counter steps and wraps. Some behaviour needs stimulus sequences, so only the bench scenarios can show it. This covers the exact tick count for each threshold setting, including 64, and the wait for a further boundary when an event lands on a boundary tick. It also covers the renewed wait after a released cause is cleared and raised again, and the read-back of reserved bits.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;

    localparam int NSRC        = 6;
    localparam int REG_W       = 32;
    localparam int THR_SEL_W   = 3;
    localparam int THR_MAX_LOG = 6;
    localparam int CNT_W       = THR_MAX_LOG;

    typedef logic [NSRC-1:0] src_vec_t;

    // positions 2 (port change), 3 (rollover), 4 (system error) fire at once
    localparam src_vec_t IMM_MASK = 6'b011100;
    localparam src_vec_t DEF_MASK = ~IMM_MASK;

    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [REG_W-1:0] data;
    } reg_req_t;

    // number of ticks per threshold interval
    function automatic logic [CNT_W:0] thr_limit(input logic [THR_SEL_W-1:0] s);
        if (int'(s) > THR_MAX_LOG)
            return (CNT_W+1)'(1) << THR_MAX_LOG;
        return (CNT_W+1)'(1) << s;
    endfunction

endpackage

// File: rtl/hc_irq_status.sv
module hc_irq_status
    import hc_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt_i,
    input  src_vec_t clr_i,
    output src_vec_t st_o
);

    src_vec_t st_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                st_q[i] <= 1'b0;
            else if (evt_i[i])
                st_q[i] <= 1'b1;          // event has priority over clear
            else if (clr_i[i])
                st_q[i] <= 1'b0;
        end
    end

    assign st_o = st_q;

    // R4: an event always leaves its bit set
    p_evt_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((st_q & $past(evt_i)) == $past(evt_i)));

    // R5: a bit only falls after a software clear
    p_no_selfclear_r5: assert property (@(posedge clk) disable iff (rst)
        (($past(st_q) & ~st_q & ~$past(clr_i)) == '0));

endmodule

// File: rtl/hc_irq_thresh.sv
module hc_irq_thresh
    import hc_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic [THR_SEL_W-1:0] sel_i,
    output logic                 strobe_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   limit;
    logic             last;

    assign limit    = thr_limit(sel_i);
    assign last     = ({1'b0, cnt_q} >= (limit - 1'b1));
    assign strobe_o = tick_i & last;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= last ? '0 : cnt_q + 1'b1;
    end

    // R7: the counter restarts after each boundary
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> (cnt_q == '0));

    // R7: a non-boundary tick advances the count by one
    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !strobe_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/hc_irq_gate.sv
module hc_irq_gate
    import hc_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t st_i,
    input  src_vec_t en_i,
    input  logic     strobe_i,
    output logic     irq_o
);

    src_vec_t qual;
    src_vec_t armed_q;
    src_vec_t armed_d;
    logic     irq_d;
    logic     irq_q;

    assign qual    = st_i & en_i;
    // batched causes stay armed only while still qualified
    assign armed_d = qual & DEF_MASK & (armed_q | {NSRC{strobe_i}});
    assign irq_d   = (|(qual & IMM_MASK)) | (|armed_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            armed_q <= armed_d;
            irq_q   <= irq_d;
        end
    end

    assign irq_o = irq_q;

    // R6: urgent enabled cause raises the line on the next edge
    p_imm_fire_r6: assert property (@(posedge clk) disable iff (rst)
        (|(st_i & en_i & IMM_MASK)) |=> irq_o);

    // R8: no line without an enabled, set cause in the prior cycle
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|(st_i & en_i)));

    // R7: a rise without an urgent cause needs a boundary strobe
    p_defer_wait_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_o) && !$past(|(st_i & en_i & IMM_MASK))) |-> $past(strobe_i));

endmodule

// File: rtl/hc_irq_aggr.sv
module hc_irq_aggr
    import hc_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic [THR_SEL_W-1:0] thr_sel_i,
    input  logic [NSRC-1:0]      evt_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_sel_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    output logic                 irq_o
);

    reg_req_t req;
    src_vec_t en_q;
    src_vec_t st;
    src_vec_t clr;
    logic     strobe;
    logic     unused_hi;

    assign req.wr   = reg_wr_i;
    assign req.sel  = reg_sel_e'(reg_sel_i);
    assign req.data = reg_wdata_i;

    assign unused_hi = ^req.data[REG_W-1:NSRC];

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (req.wr && req.sel == REG_ENABLE)
            en_q <= req.data[NSRC-1:0];
    end

    assign clr = (req.wr && req.sel == REG_STATUS) ? req.data[NSRC-1:0] : '0;

    always_comb begin
        reg_rdata_o = '0;
        if (req.sel == REG_STATUS)
            reg_rdata_o[NSRC-1:0] = st;
        else
            reg_rdata_o[NSRC-1:0] = en_q;
    end

    hc_irq_status u_status (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_i),
        .clr_i (clr),
        .st_o  (st)
    );

    hc_irq_thresh u_thresh (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .sel_i    (thr_sel_i),
        .strobe_o (strobe)
    );

    hc_irq_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .st_i     (st),
        .en_i     (en_q),
        .strobe_i (strobe),
        .irq_o    (irq_o)
    );

    // R2: an enable write lands in the next cycle
    p_en_write_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && !reg_sel_i) |=> (en_q == $past(reg_wdata_i[NSRC-1:0])));

endmodule

// File: tb/hc_irq_aggr_bench.sv
`timescale 1ns/1ps
module hc_irq_aggr_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [2:0]  thr_sel_i = 3'd0;
    logic [5:0]  evt_i = '0;
    logic        reg_wr_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hc_irq_aggr u_hc_irq_aggr (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .thr_sel_i   (thr_sel_i),
        .evt_i       (evt_i),
        .reg_wr_i    (reg_wr_i),
        .reg_sel_i   (reg_sel_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick_i = 0; evt_i = '0; reg_wr_i = 0; reg_sel_i = 0; reg_wdata_i = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel_i = sel;
        #1 d = reg_rdata_o;
    endtask

    task automatic pulse(input logic [5:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(0, d); chk("R1 enable", d, 32'h0);
        rd(1, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        do_reset();
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); chk("R2 enable all ones", d, 32'h3F);
        wr(0, 32'hABCD_0015);
        rd(0, d); chk("R2 enable pattern", d, 32'h15);
        wr(1, 32'hFFFF_FFC0);
        rd(1, d); chk("R2 status reserved", d, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        do_reset();
        pulse(6'b101010);
        rd(1, d); chk("R3 set", d, 32'h2A);
        repeat (20) @(negedge clk);
        rd(1, d); chk("R5 no self clear", d, 32'h2A);
        wr(1, 32'h0A);
        rd(1, d); chk("R3 w1c", d, 32'h20);
        wr(1, 32'h0);
        rd(1, d); chk("R3 write zero", d, 32'h20);
    endtask

    task automatic t_evt_wins();
        logic [31:0] d;
        do_reset();
        pulse(6'h09);
        evt_i = 6'h08; reg_wr_i = 1; reg_sel_i = 1; reg_wdata_i = 32'h09;
        @(negedge clk);
        evt_i = '0; reg_wr_i = 0; reg_wdata_i = '0;
        rd(1, d); chk("R4 event wins", d, 32'h08);
    endtask

    task automatic t_immediate();
        logic [31:0] d;
        do_reset();
        wr(0, 32'h1C);
        pulse(6'h04);
        chk("R6 not yet", irq_o, 0);
        @(negedge clk);
        chk("R6 port change fires", irq_o, 1);
        wr(1, 32'h04);
        chk("R9 still high", irq_o, 1);
        @(negedge clk);
        chk("R9 falls after clear", irq_o, 0);
        pulse(6'h10);
        @(negedge clk);
        chk("R6 system error fires", irq_o, 1);
        wr(0, 32'h0C);
        @(negedge clk);
        chk("R9 falls after disable", irq_o, 0);
        rd(1, d); chk("R9 status kept", d, 32'h10);
        wr(0, 32'h1C);
        @(negedge clk);
        chk("R6 re-enable", irq_o, 1);
    endtask

    task automatic t_disabled();
        do_reset();
        thr_sel_i = 3'd0;
        pulse(6'h3F);
        repeat (3) tick();
        chk("R8 disabled no irq", irq_o, 0);
    endtask

    task automatic t_deferred();
        do_reset();
        thr_sel_i = 3'd2;
        wr(0, 32'h23);
        pulse(6'h01);
        @(negedge clk);
        chk("R7 no immediate", irq_o, 0);
        repeat (3) tick();
        chk("R7 before boundary", irq_o, 0);
        tick();
        chk("R7 at boundary", irq_o, 1);
        repeat (2) tick();
        chk("R10 holds", irq_o, 1);
        wr(1, 32'h01);
        @(negedge clk);
        chk("R9 deferred cleared", irq_o, 0);
        pulse(6'h02);
        @(negedge clk);
        tick();
        chk("R10 rewait", irq_o, 0);
        tick();
        chk("R10 next boundary", irq_o, 1);
    endtask

    task automatic t_sel64();
        do_reset();
        thr_sel_i = 3'd7;
        wr(0, 32'h02);
        pulse(6'h02);
        repeat (63) tick();
        chk("R7 64 ticks not yet", irq_o, 0);
        tick();
        chk("R7 64 ticks boundary", irq_o, 1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        thr_sel_i = 3'd0;
        wr(0, 32'h20);
        evt_i = 6'h20; tick_i = 1;
        @(negedge clk);
        evt_i = '0; tick_i = 0;
        @(negedge clk);
        chk("R7 same cycle waits", irq_o, 0);
        tick();
        chk("R7 following boundary", irq_o, 1);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_status();
        t_evt_wins();
        t_immediate();
        t_disabled();
        t_deferred();
        t_sel64();
        t_same_cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule